// File: doc/BRIEF.md
# External Bus Byte-Lane Sequencer

This block connects a 32-bit internal memory request port to an external asynchronous-memory bus that has separate address and data lines. Each request can be a byte, a half-word or a word. The block turns it into one or more external beats. Every beat drives the address lines, a chip select, a read strobe or the byte write strobes, and the write data. When a read completes, the returned bytes are put back together into one right-justified 32-bit word.

The top two address bits select one of four regions. Each region has its own fixed wait count. Each region also has a bus width: region 0 takes its width from a static strap input, and regions 1 to 3 take theirs from a width bit (0 = 8-bit). On an 8-bit region a wide request is split into byte beats on data lines 7..0, least significant byte first. On a 16-bit region a half-word goes out as a single beat on lines 15..0. There is no ready input from the external side. Each beat ends when its region's wait count runs out.

The requester presents a request while `req_ready` is high. Completion is signalled by a single-cycle `done` pulse, and `rdata` is valid while `done` is high.

Top module: `ebus_byte_seq`

## Requirements
- R1: After reset, all chip selects are high, `ext_re_n` is 1, `ext_we_n` is 2'b11, `done` is 0 and `req_ready` is 1.
- R2: The region is taken from `req_addr[ADDR_W-1:ADDR_W-2]`. For the whole request only `ext_cs_n[region]` is low, including the idle clocks between beats.
- R3: On an 8-bit region a half-word request (`req_size`=1) makes two beats. The first is at the request address (bit 0 = 0) and carries byte 0. The second is at address+1 and carries byte 1.
- R4: On an 8-bit region a word request (`req_size`=2) makes four beats, with address bits [1:0] going 00, 01, 10, 11 and byte 0 first.
- R5: A byte request (`req_size`=0) makes exactly one beat at its own address.
- R6: Each beat holds its strobe low for `cfg_wait[4*r +: 4]`+1 clocks, where r is the region.
- R7: Consecutive beats are separated by at least one clock with all strobes high. While a strobe is low, `ext_addr` and `ext_dout` do not change.
- R8: A read beat drives `ext_re_n` low with `ext_we_n`=2'b11. A write beat on an 8-bit region drives `ext_we_n`=2'b10 (lane 0 low), with the byte on `ext_dout[7:0]`. The two kinds of strobe are never low together.
- R9: For a read, the bytes are sampled on the last strobe clock of each beat. They appear right-justified in `rdata`, byte k coming from address+k, while `done` is high.
- R10: `done` is a single-cycle pulse that comes on the clock after the idle clock that follows the final beat. `req_ready` is low from the moment a request is accepted until then.
- R11: Region 0 is 16-bit when `boot_wide`=1, and region r≥1 is 16-bit when `cfg_wide[r-1]`=1. On a 16-bit region a half-word is one beat on `ext_dout[15:0]`/`ext_din[15:0]` with `ext_we_n`=2'b00 when writing. A word is two such beats at address and address+2.
- R12: On a 16-bit region a byte request uses lane `addr[0]`: on a write `ext_we_n` is 2'b10 for an even address and 2'b01 for an odd one, with the data on that lane. On a read the byte comes from that lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_addr | input | ADDR_W | Request address, aligned to its size |
| req_wdata | input | 32 | Write data, right-justified |
| req_ready | output | 1 | Block idle; a request is accepted this clock |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read data, right-justified |
| cfg_wait | input | NREG*WAIT_W | Fixed wait count per region |
| cfg_wide | input | NREG-1 | Width bit for regions 1..NREG-1 (1 = 16-bit) |
| boot_wide | input | 1 | Static width strap for region 0 |
| ext_addr | output | ADDR_W | External address |
| ext_cs_n | output | NREG | Active-low chip selects, one per region |
| ext_re_n | output | 1 | Active-low read strobe |
| ext_we_n | output | 2 | Active-low byte write strobes, lane 1..0 |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |

## Verification
The hardest cases to reach from the ports are where the byte order and the lane choice could go wrong without being seen. One is a word split across four beats, where a lane mix-up only shows if every byte is different. Another is a 16-bit region where byte requests must switch lanes by address parity. The stimulus writes distinct byte patterns through one region width and reads them back, and it mixes regions with different widths. The width strap is flipped between requests, and a region's wait count is reprogrammed, including a wait of 0, which gives the shortest strobe and the shortest gap between beats.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ACT = 2'd1, ST_GAP = 2'd2} seq_state_e;

  // index of the final beat for a request
  function automatic logic [1:0] last_beat(logic wide, logic [1:0] sz);
    if (sz == SZ_BYTE) return 2'd0;
    if (wide) return (sz == SZ_WORD) ? 2'd1 : 2'd0;
    return (sz == SZ_WORD) ? 2'd3 : 2'd1;
  endfunction
endpackage

// File: rtl/ebus_region_sel.sv
module ebus_region_sel #(
  parameter int ADDR_W = 24,
  parameter int WAIT_W = 4,
  parameter int NREG   = 4,
  localparam int RGN_W = $clog2(NREG)
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NREG*WAIT_W-1:0] cfg_wait,
  input  logic [NREG-2:0]        cfg_wide,
  input  logic                   boot_wide,
  output logic [WAIT_W-1:0]      wait_cnt,
  output logic                   wide,
  output logic [NREG-1:0]        cs_vec
);
  logic [RGN_W-1:0] rgn;
  logic [NREG-1:0]  wide_vec;

  assign rgn = addr[ADDR_W-1 -: RGN_W];
  assign wide_vec[0] = boot_wide;

  genvar g;
  generate
    for (g = 1; g < NREG; g++) begin : g_wide
      assign wide_vec[g] = cfg_wide[g-1];
    end
  endgenerate

  assign wide     = wide_vec[rgn];
  assign wait_cnt = cfg_wait[rgn*WAIT_W +: WAIT_W];
  assign cs_vec   = {{(NREG-1){1'b0}}, 1'b1} << rgn;
endmodule

// File: rtl/ebus_wait_timer.sv
module ebus_wait_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  output logic              expire
);
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/ebus_rd_assemble.sv
module ebus_rd_assemble (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        capture,
  input  logic        wide,
  input  logic [1:0]  size,
  input  logic [1:0]  bidx,
  input  logic        a0,
  input  logic [15:0] din,
  output logic [31:0] rdata
);
  import ebus_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clear) rdata <= '0;
    else if (capture) begin
      if (wide && size != SZ_BYTE) rdata[16*bidx[0] +: 16] <= din;
      else if (wide)               rdata[7:0] <= a0 ? din[15:8] : din[7:0];
      else                         rdata[8*bidx +: 8] <= din[7:0];
    end
  end

  // R9: assembled word only changes when a beat is captured or a request starts
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!clear && !capture) |=> $stable(rdata));
endmodule

// File: rtl/ebus_byte_seq.sv
module ebus_byte_seq #(
  parameter int ADDR_W = 24,
  parameter int WAIT_W = 4,
  parameter int NREG   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [1:0]             req_size,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   req_ready,
  output logic                   done,
  output logic [31:0]            rdata,
  input  logic [NREG*WAIT_W-1:0] cfg_wait,
  input  logic [NREG-2:0]        cfg_wide,
  input  logic                   boot_wide,
  output logic [ADDR_W-1:0]      ext_addr,
  output logic [NREG-1:0]        ext_cs_n,
  output logic                   ext_re_n,
  output logic [1:0]             ext_we_n,
  output logic [15:0]            ext_dout,
  input  logic [15:0]            ext_din
);
  import ebus_pkg::*;

  seq_state_e        state;
  logic              r_write, r_wide;
  logic [1:0]        r_size, bidx, blast;
  logic [31:0]       r_wdata;
  logic [WAIT_W-1:0] r_wait;

  logic [WAIT_W-1:0] sel_wait;
  logic              sel_wide;
  logic [NREG-1:0]   sel_cs;
  logic              t_expire, accept, next_beat, t_load;

  // beat-start operands: request fields when idle, latched fields otherwise
  logic              s_write, s_wide, s_a0;
  logic [1:0]        s_size, s_idx;
  logic [31:0]       s_wdata;
  logic [15:0]       s_dout;
  logic [1:0]        s_we;
  logic [ADDR_W-1:0] step;

  ebus_region_sel #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .NREG(NREG)) u_sel (
    .addr(req_addr), .cfg_wait(cfg_wait), .cfg_wide(cfg_wide), .boot_wide(boot_wide),
    .wait_cnt(sel_wait), .wide(sel_wide), .cs_vec(sel_cs));

  assign accept    = (state == ST_IDLE) && req_valid;
  assign next_beat = (state == ST_GAP) && (bidx != blast);
  assign t_load    = accept || next_beat;
  assign req_ready = (state == ST_IDLE);

  ebus_wait_timer #(.WAIT_W(WAIT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(t_load),
    .load_val(accept ? sel_wait : r_wait), .expire(t_expire));

  ebus_rd_assemble u_asm (
    .clk(clk), .rst(rst), .clear(accept),
    .capture((state == ST_ACT) && t_expire && !r_write),
    .wide(r_wide), .size(r_size), .bidx(bidx), .a0(ext_addr[0]),
    .din(ext_din), .rdata(rdata));

  always_comb begin
    s_write = accept ? req_write : r_write;
    s_wide  = accept ? sel_wide  : r_wide;
    s_size  = accept ? req_size  : r_size;
    s_wdata = accept ? req_wdata : r_wdata;
    s_idx   = accept ? 2'd0      : bidx + 2'd1;
    s_a0    = accept ? req_addr[0] : ext_addr[0];
    step    = (r_wide && r_size != SZ_BYTE) ? ADDR_W'(2) : ADDR_W'(1);
    if (s_wide && s_size != SZ_BYTE) begin
      s_dout = s_wdata[16*s_idx[0] +: 16];
      s_we   = 2'b00;
    end else if (s_wide) begin
      s_dout = {s_wdata[7:0], s_wdata[7:0]};
      s_we   = s_a0 ? 2'b01 : 2'b10;
    end else begin
      s_dout = {8'h00, s_wdata[8*s_idx +: 8]};
      s_we   = 2'b10;
    end
    if (!s_write) s_we = 2'b11;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ext_cs_n <= '1;
      ext_re_n <= 1'b1;
      ext_we_n <= 2'b11;
      ext_addr <= '0;
      ext_dout <= '0;
      done     <= 1'b0;
      bidx     <= '0;
      blast    <= '0;
      r_write  <= 1'b0;
      r_wide   <= 1'b0;
      r_size   <= '0;
      r_wdata  <= '0;
      r_wait   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          r_write  <= req_write;
          r_wide   <= sel_wide;
          r_size   <= req_size;
          r_wdata  <= req_wdata;
          r_wait   <= sel_wait;
          blast    <= last_beat(sel_wide, req_size);
          bidx     <= '0;
          ext_addr <= req_addr;
          ext_cs_n <= ~sel_cs;
          ext_dout <= s_dout;
          ext_we_n <= s_we;
          ext_re_n <= req_write;
          state    <= ST_ACT;
        end
        ST_ACT: if (t_expire) begin
          ext_re_n <= 1'b1;
          ext_we_n <= 2'b11;
          state    <= ST_GAP;
        end
        ST_GAP: if (next_beat) begin
          bidx     <= s_idx;
          ext_addr <= ext_addr + step;
          ext_dout <= s_dout;
          ext_we_n <= s_we;
          ext_re_n <= r_write;
          state    <= ST_ACT;
        end else begin
          done     <= 1'b1;
          ext_cs_n <= '1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic strobe;
  assign strobe = !ext_re_n || (ext_we_n != 2'b11);

  a_r8_one_kind: assert property (@(posedge clk) disable iff (rst)
    !(!ext_re_n && ext_we_n != 2'b11));
  a_r2_cs_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ext_cs_n));
  a_r2_strobe_has_cs: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (~ext_cs_n != '0));
  a_r7_stable: assert property (@(posedge clk) disable iff (rst)
    (strobe && $past(strobe)) |-> ($stable(ext_addr) && $stable(ext_dout)));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (!strobe && ext_cs_n == '1));
endmodule

// File: tb/sim_ebus_byte_seq.sv
`timescale 1ns/1ps
module sim_ebus_byte_seq;
  localparam int ADDR_W = 24;

  typedef struct packed {
    logic [23:0] addr;
    logic        rd;
    logic [1:0]  we;
    logic [15:0] dout;
    logic [15:0] mask;
    logic [4:0]  len;
    logic [3:0]  csn;
  } beat_t;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_size = 0;
  logic [23:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, done;
  logic [31:0] rdata;
  logic [15:0] cfg_wait;
  logic [2:0] cfg_wide;
  logic boot_wide;
  logic [23:0] ext_addr;
  logic [3:0] ext_cs_n;
  logic ext_re_n;
  logic [1:0] ext_we_n;
  logic [15:0] ext_dout, ext_din;

  int n_chk = 0, n_bad = 0;
  logic [7:0] bus_mem [256];
  logic [7:0] ref_mem [256];
  beat_t beat_q[$];
  logic [32:0] done_q[$];

  always #2 clk = ~clk;

  ebus_byte_seq #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rdata(rdata),
    .cfg_wait(cfg_wait), .cfg_wide(cfg_wide), .boot_wide(boot_wide),
    .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_re_n(ext_re_n),
    .ext_we_n(ext_we_n), .ext_dout(ext_dout), .ext_din(ext_din));

  function automatic logic rgn_wide(logic [1:0] r);
    return (r == 0) ? boot_wide : cfg_wide[r-1];
  endfunction

  function automatic logic [1:0] cs_rgn(logic [3:0] csn);
    for (int i = 0; i < 4; i++) if (!csn[i]) return 2'(i);
    return 2'd0;
  endfunction

  // external memory model
  logic bus_wide;
  assign bus_wide = rgn_wide(cs_rgn(ext_cs_n));
  always_comb begin
    if (bus_wide) ext_din = {bus_mem[{ext_addr[7:1], 1'b1}], bus_mem[{ext_addr[7:1], 1'b0}]};
    else          ext_din = {8'hEE, bus_mem[ext_addr[7:0]]};
  end
  always @(posedge clk) begin
    if (!rst) begin
      if (bus_wide) begin
        if (!ext_we_n[0]) bus_mem[{ext_addr[7:1], 1'b0}] <= ext_dout[7:0];
        if (!ext_we_n[1]) bus_mem[{ext_addr[7:1], 1'b1}] <= ext_dout[15:8];
      end else if (!ext_we_n[0]) bus_mem[ext_addr[7:0]] <= ext_dout[7:0];
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: build expectations, then issue request and wait for done
  task automatic do_req(input logic wr, input logic [1:0] sz, input logic [23:0] a, input logic [31:0] wd);
    logic [1:0] r = a[23:22];
    logic wide = rgn_wide(r);
    logic [4:0] ln = 5'(cfg_wait[4*r +: 4]) + 5'd1;
    logic [31:0] exp_rd = 0;
    int nb;
    beat_t b;
    b.rd = !wr; b.len = ln; b.csn = ~(4'b1 << r);
    if (wide && sz != 2'd0) begin
      nb = (sz == 2'd2) ? 2 : 1;
      for (int i = 0; i < nb; i++) begin
        b.addr = a + 24'(2*i); b.we = wr ? 2'b00 : 2'b11;
        b.dout = wd[16*i +: 16]; b.mask = wr ? 16'hFFFF : 16'h0;
        beat_q.push_back(b);
      end
    end else if (wide) begin
      b.addr = a; b.we = wr ? (a[0] ? 2'b01 : 2'b10) : 2'b11;
      b.dout = {wd[7:0], wd[7:0]}; b.mask = wr ? (a[0] ? 16'hFF00 : 16'h00FF) : 16'h0;
      beat_q.push_back(b);
    end else begin
      nb = 1 << sz;
      for (int i = 0; i < nb; i++) begin
        b.addr = a + 24'(i); b.we = wr ? 2'b10 : 2'b11;
        b.dout = {8'h00, wd[8*i +: 8]}; b.mask = wr ? 16'h00FF : 16'h0;
        beat_q.push_back(b);
      end
    end
    for (int k = 0; k < (1 << sz); k++) begin
      if (wr) ref_mem[a[7:0] + 8'(k)] = wd[8*k +: 8];
      else    exp_rd[8*k +: 8] = ref_mem[a[7:0] + 8'(k)];
    end
    done_q.push_back({!wr, exp_rd});
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  logic prev_strobe = 0, prev_done = 0;
  int len_cnt = 0;
  beat_t cur;
  logic [23:0] start_addr;
  logic [32:0] dexp;
  always @(negedge clk) begin
    logic strobe;
    strobe = !ext_re_n || (ext_we_n != 2'b11);
    if (rst) begin
      prev_strobe = 0; prev_done = 0; len_cnt = 0;
    end else begin
      if (strobe && !prev_strobe) begin
        if (beat_q.size() == 0) check(0, "R5 unexpected beat", 32'(ext_addr), 0);
        else begin
          cur = beat_q.pop_front();
          check(ext_addr == cur.addr, "R3 R4 R5 beat address", 32'(ext_addr), 32'(cur.addr));
          check(ext_cs_n == cur.csn, "R2 chip select", 32'(ext_cs_n), 32'(cur.csn));
          check(ext_re_n == !cur.rd, "R8 read strobe", 32'(ext_re_n), 32'(!cur.rd));
          check(ext_we_n == cur.we, "R8 R11 R12 write lanes", 32'(ext_we_n), 32'(cur.we));
          check((ext_dout & cur.mask) == (cur.dout & cur.mask), "R3 R4 R11 R12 write data",
                32'(ext_dout & cur.mask), 32'(cur.dout & cur.mask));
          check(req_ready == 0, "R10 busy while beating", 32'(req_ready), 0);
        end
        start_addr = ext_addr;
        len_cnt = 0;
      end
      if (strobe) begin
        len_cnt++;
        if (prev_strobe) check(ext_addr == start_addr, "R7 address stable", 32'(ext_addr), 32'(start_addr));
      end
      if (!strobe && prev_strobe)
        check(len_cnt == int'(cur.len), "R6 strobe length", 32'(len_cnt), 32'(cur.len));
      if (done) begin
        check(!prev_done, "R10 done one cycle", 32'(prev_done), 0);
        check(!strobe, "R7 R10 no strobe at done", 32'(strobe), 0);
        if (done_q.size() == 0) check(0, "R10 unexpected done", 0, 0);
        else begin
          dexp = done_q.pop_front();
          if (dexp[32]) check(rdata == dexp[31:0], "R9 read data", rdata, dexp[31:0]);
        end
      end
      prev_strobe = strobe;
      prev_done = done;
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    check(0, "watchdog expired", 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      bus_mem[i] = 8'(i * 37 + 11);
      ref_mem[i] = 8'(i * 37 + 11);
    end
    cfg_wait = {4'd1, 4'd3, 4'd0, 4'd2};  // region3..0
    cfg_wide = 3'b100;                    // region3 16-bit
    boot_wide = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(ext_cs_n == 4'hF, "R1 cs after reset", 32'(ext_cs_n), 32'hF);
    check(ext_re_n == 1, "R1 re after reset", 32'(ext_re_n), 1);
    check(ext_we_n == 2'b11, "R1 we after reset", 32'(ext_we_n), 3);
    check(done == 0, "R1 done after reset", 32'(done), 0);
    check(req_ready == 1, "R1 ready after reset", 32'(req_ready), 1);

    do_req(0, 2'd2, 24'h000010, 0);              // R4 word read, region 0
    do_req(1, 2'd1, 24'h400022, 32'h0000A55A);   // R3 half write, wait 0
    do_req(0, 2'd1, 24'h400022, 0);              // R3 R9
    do_req(1, 2'd0, 24'h800033, 32'h7E);         // R5 byte write
    do_req(0, 2'd0, 24'h800033, 0);
    do_req(1, 2'd2, 24'h800040, 32'h12345678);   // R4 word write
    do_req(0, 2'd2, 24'h800040, 0);
    do_req(1, 2'd1, 24'hC00050, 32'hBEEF);       // R11 wide half
    do_req(0, 2'd1, 24'hC00050, 0);
    do_req(1, 2'd0, 24'hC00061, 32'h44);         // R12 odd lane
    do_req(0, 2'd0, 24'hC00061, 0);
    do_req(1, 2'd0, 24'hC00064, 32'h9A);         // R12 even lane
    do_req(0, 2'd0, 24'hC00064, 0);
    do_req(1, 2'd2, 24'hC00070, 32'hCAFEF00D);   // R11 wide word
    do_req(0, 2'd2, 24'hC00070, 0);
    boot_wide = 1;                                // R11 region 0 from strap
    do_req(0, 2'd1, 24'h000080, 0);
    do_req(1, 2'd1, 24'h000090, 32'h3C5A);
    do_req(0, 2'd1, 24'h000090, 0);
    boot_wide = 0;
    do_req(0, 2'd2, 24'h000090, 0);
    cfg_wait[7:4] = 4'd5;                          // R6 reprogrammed wait
    do_req(0, 2'd0, 24'h4000A1, 0);
    do_req(1, 2'd2, 24'h4000B0, 32'h0F1E2D3C);
    do_req(0, 2'd2, 24'h4000B0, 0);

    repeat (4) @(negedge clk);
    check(beat_q.size() == 0, "R5 all beats seen", 32'(beat_q.size()), 0);
    check(done_q.size() == 0, "R10 all done seen", 32'(done_q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule